// File: doc/BRIEF.md
# Precise Exception Flush Controller

This controller sits beside a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Any of the first four stages may flag a fault for the instruction it holds, with a 3-bit cause code. The controller does not act on a flag when it appears. It attaches the flag to the instruction and carries it down the pipeline, following the advance signal. The flag is acted on only when that instruction reaches the memory stage, the last stage where a fault can still be raised. When several instructions carry flags, the oldest one is therefore always taken first, whatever order the flags were raised in.

When an exception is taken, the controller flushes the memory, execute, decode and fetch stages in that same cycle, so the faulting instruction and everything younger become bubbles. The instruction in writeback retires. All carried flags are discarded, because the flush removes the instructions they belong to. On the next clock edge the controller loads the exception return address (faulting PC plus 4) and the cause code. For one cycle it also steers the fetch PC to the handler entry 0x40000040. In every other cycle the fetch PC is the pipeline's normal next PC.

Top module: `xcpt_flush_ctrl`

## Requirements
- R1: While reset is held and before any exception: take_o=0, flush_o=0, redir_o=0, epc_o=0, cause_o=0, and fetch_pc_o equals nxt_pc_i.
- R2: A valid memory-stage instruction with a flag (stg_vld_i[3] and xreq_i[3]) is taken in the same cycle: take_o=1 and flush_o=5'b01111 (bit 0 fetch, 1 decode, 2 execute, 3 memory, 4 writeback; bit 4 is never set). Without a take, flush_o=0.
- R3: A flag raised in fetch, decode or execute is not taken at once. It moves one stage on each cycle with adv_i=1 and holds while adv_i=0. It is taken in the cycle its instruction occupies the memory stage.
- R4: When several stages flag in the same cycle, the instruction nearest writeback wins, and its cause is recorded.
- R5: A take discards every carried flag, so no second take follows from instructions flushed by the first. take_o is never high in two consecutive cycles.
- R6: On the edge after a take, epc_o is loaded with mem_pc_i+4 from the take cycle. epc_o and cause_o change at no other time.
- R7: Cause codes are: 0 external request, 1 system call, 2 arithmetic overflow, 3 page fault, 4 undefined instruction. cause_o is loaded with the code of the taken instruction.
- R8: In the cycle after a take, redir_o=1 and fetch_pc_o=0x40000040. Otherwise redir_o=0 and fetch_pc_o=nxt_pc_i.
- R9: A flag whose stage-valid bit is low is ignored. All flags are ignored in the redirect cycle.
- R10: If an instruction already carries a flag, a later flag for the same instruction does not replace its cause; the first detected cause is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| adv_i | input | 1 | Pipeline advances this cycle (0 = stall) |
| stg_vld_i | input | 4 | Stage holds a valid instruction; bit 0 fetch to bit 3 memory |
| xreq_i | input | 4 | Per-stage fault flag, same bit order |
| xcause_i | input | 12 | Per-stage cause code, 3 bits per stage, stage s at [3s+2:3s] |
| mem_pc_i | input | 32 | PC of the instruction in the memory stage |
| nxt_pc_i | input | 32 | Normal next fetch PC from the pipeline |
| take_o | output | 1 | Exception taken this cycle |
| flush_o | output | 5 | Per-stage flush (turn into bubble), bit 0 fetch to bit 4 writeback |
| epc_o | output | 32 | Exception return address |
| cause_o | output | 3 | Recorded cause code |
| redir_o | output | 1 | Fetch is redirected to the handler this cycle |
| fetch_pc_o | output | 32 | Selected fetch PC |

## Verification
The bench raises a fault in fetch one cycle before an older instruction faults in memory. A controller that arbitrated by arrival time would take the younger fault, or take it again later, instead of discarding it. The bench raises execute and memory faults together and expects the page-fault cause; a stage-order inversion would record overflow. Flags raised with an invalid stage, flags raised in the redirect cycle, and a second flag on an instruction that already carries one must not cause an extra take or change the cause. A deferred fault is also held across a stall cycle, so an off-by-one in the record shift would change the cycle in which it is taken.

// File: rtl/xf_pkg.sv
package xf_pkg;
  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    XC_EXT = 3'd0,
    XC_SYS = 3'd1,
    XC_OVF = 3'd2,
    XC_PGF = 3'd3,
    XC_UND = 3'd4
  } xcause_e;

  typedef struct packed {
    logic               vld;
    logic [CAUSE_W-1:0] code;
  } xrec_t;
endpackage

// File: rtl/xf_rst_sync.sv
module xf_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_no = sync_q[1];
endmodule

// File: rtl/xf_stage_track.sv
// Carries each instruction's first detected fault alongside it, one record per stage.
module xf_stage_track
  import xf_pkg::*;
#(
  parameter int NCHK = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic                    kill_i,
  input  logic [NCHK-1:0]         raw_vld_i,
  input  logic [NCHK*CAUSE_W-1:0] raw_code_i,
  output xrec_t                   commit_o
);
  xrec_t [NCHK-1:0] rec_q, rec_d, eff;
  logic             rec_en;

  for (genvar s = 0; s < NCHK; s++) begin : g_eff
    // an earlier record wins over a fresh flag for the same instruction (R10)
    assign eff[s] = rec_q[s].vld ? rec_q[s]
                  : xrec_t'{vld: raw_vld_i[s], code: raw_code_i[s*CAUSE_W +: CAUSE_W]};
  end

  for (genvar s = 0; s < NCHK; s++) begin : g_next
    if (s == 0) begin : g_head
      always_comb begin
        if (kill_i)     rec_d[s] = '0;
        else if (adv_i) rec_d[s] = '0;
        else            rec_d[s] = eff[s];
      end
    end else begin : g_body
      always_comb begin
        if (kill_i)     rec_d[s] = '0;
        else if (adv_i) rec_d[s] = eff[s-1];
        else            rec_d[s] = eff[s];
      end
    end
  end

  assign rec_en = adv_i | kill_i | (|raw_vld_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rec_q <= '0;
    else if (rec_en) rec_q <= rec_d;
  end

  assign commit_o = eff[NCHK-1];
endmodule

// File: rtl/xf_take_arb.sv
// Takes the record sitting at the last faulting stage and builds the flush mask.
module xf_take_arb
  import xf_pkg::*;
#(
  parameter int NSTG = 5,
  localparam int NCHK = NSTG - 1
) (
  input  xrec_t              commit_i,
  input  logic               commit_vld_i,
  output logic               take_o,
  output logic [CAUSE_W-1:0] code_o,
  output logic [NSTG-1:0]    flush_o
);
  assign take_o = commit_i.vld & commit_vld_i;
  assign code_o = commit_i.code;

  for (genvar i = 0; i < NSTG; i++) begin : g_flush
    if (i < NCHK) begin : g_kill
      assign flush_o[i] = take_o;
    end else begin : g_keep
      assign flush_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/xf_arch_regs.sv
module xf_arch_regs
  import xf_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h4000_0040,
  parameter int              PC_STEP    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               take_i,
  input  logic [CAUSE_W-1:0] code_i,
  input  logic [XLEN-1:0]    fault_pc_i,
  input  logic [XLEN-1:0]    nxt_pc_i,
  output logic [XLEN-1:0]    epc_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               redir_o,
  output logic [XLEN-1:0]    fetch_pc_o
);
  logic [XLEN-1:0]    epc_q, epc_d;
  logic [CAUSE_W-1:0] cause_q, cause_d;
  logic               redir_q;

  always_comb begin
    epc_d   = fault_pc_i + XLEN'(PC_STEP);
    cause_d = code_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (take_i) begin
      epc_q   <= epc_d;
      cause_q <= cause_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) redir_q <= 1'b0;
    else         redir_q <= take_i;
  end

  assign epc_o      = epc_q;
  assign cause_o    = cause_q;
  assign redir_o    = redir_q;
  assign fetch_pc_o = redir_q ? HANDLER_PC : nxt_pc_i;
endmodule

// File: rtl/xcpt_flush_ctrl.sv
module xcpt_flush_ctrl
  import xf_pkg::*;
#(
  parameter int              XLEN       = 32,
  parameter int              NSTG       = 5,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h4000_0040,
  parameter int              PC_STEP    = 4,
  localparam int             NCHK       = NSTG - 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    adv_i,
  input  logic [NCHK-1:0]         stg_vld_i,
  input  logic [NCHK-1:0]         xreq_i,
  input  logic [NCHK*CAUSE_W-1:0] xcause_i,
  input  logic [XLEN-1:0]         mem_pc_i,
  input  logic [XLEN-1:0]         nxt_pc_i,
  output logic                    take_o,
  output logic [NSTG-1:0]         flush_o,
  output logic [XLEN-1:0]         epc_o,
  output logic [CAUSE_W-1:0]      cause_o,
  output logic                    redir_o,
  output logic [XLEN-1:0]         fetch_pc_o
);
  logic               rst_n_s;
  logic [NCHK-1:0]    raw_vld;
  logic               commit_vld;
  xrec_t              commit_rec;
  logic               take;
  logic [CAUSE_W-1:0] take_code;

  xf_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_s)
  );

  // flags in bubbles or in the redirect cycle are dropped (R9)
  assign raw_vld    = stg_vld_i & xreq_i & {NCHK{~redir_o}};
  assign commit_vld = stg_vld_i[NCHK-1] & ~redir_o;

  xf_stage_track #(.NCHK(NCHK)) u_track (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .adv_i      (adv_i),
    .kill_i     (take),
    .raw_vld_i  (raw_vld),
    .raw_code_i (xcause_i),
    .commit_o   (commit_rec)
  );

  xf_take_arb #(.NSTG(NSTG)) u_arb (
    .commit_i     (commit_rec),
    .commit_vld_i (commit_vld),
    .take_o       (take),
    .code_o       (take_code),
    .flush_o      (flush_o)
  );

  xf_arch_regs #(
    .XLEN       (XLEN),
    .HANDLER_PC (HANDLER_PC),
    .PC_STEP    (PC_STEP)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_s),
    .take_i     (take),
    .code_i     (take_code),
    .fault_pc_i (mem_pc_i),
    .nxt_pc_i   (nxt_pc_i),
    .epc_o      (epc_o),
    .cause_o    (cause_o),
    .redir_o    (redir_o),
    .fetch_pc_o (fetch_pc_o)
  );

  assign take_o = take;
endmodule

// File: rtl/xcpt_flush_ctrl_chk.sv
module xcpt_flush_ctrl_chk #(
  parameter int              XLEN       = 32,
  parameter int              NSTG       = 5,
  parameter logic [XLEN-1:0] HANDLER_PC = 32'h4000_0040,
  parameter int              PC_STEP    = 4,
  localparam int             NCHK       = NSTG - 1
) (
  input logic             clk_i,
  input logic             rst_n_s,
  input logic [NCHK-1:0]  stg_vld_i,
  input logic [NCHK-1:0]  xreq_i,
  input logic [XLEN-1:0]  mem_pc_i,
  input logic [XLEN-1:0]  nxt_pc_i,
  input logic             take_o,
  input logic [NSTG-1:0]  flush_o,
  input logic [XLEN-1:0]  epc_o,
  input logic [2:0]       cause_o,
  input logic             redir_o,
  input logic [XLEN-1:0]  fetch_pc_o
);
  localparam logic [NSTG-1:0] FLUSH_ALL = NSTG'((1 << NCHK) - 1);

  p_flush_on_take_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    take_o |-> flush_o == FLUSH_ALL);
  p_idle_no_flush_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !take_o |-> flush_o == '0);
  p_mem_flag_taken_r2: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (stg_vld_i[NCHK-1] && xreq_i[NCHK-1] && !redir_o) |-> take_o);
  p_single_take_r5: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    take_o |=> !take_o);
  p_epc_load_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    take_o |=> epc_o == $past(mem_pc_i) + XLEN'(PC_STEP));
  p_regs_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !take_o |=> ($stable(epc_o) && $stable(cause_o)));
  p_redirect_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    take_o |=> (redir_o && fetch_pc_o == HANDLER_PC));
  p_passthru_r8: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !redir_o |-> fetch_pc_o == nxt_pc_i);
  p_no_take_bubble_r9: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    !stg_vld_i[NCHK-1] |-> !take_o);
endmodule

bind xcpt_flush_ctrl xcpt_flush_ctrl_chk #(
  .XLEN(XLEN), .NSTG(NSTG), .HANDLER_PC(HANDLER_PC), .PC_STEP(PC_STEP)
) u_chk (
  .clk_i(clk_i), .rst_n_s(rst_n_s), .stg_vld_i(stg_vld_i), .xreq_i(xreq_i),
  .mem_pc_i(mem_pc_i), .nxt_pc_i(nxt_pc_i), .take_o(take_o), .flush_o(flush_o),
  .epc_o(epc_o), .cause_o(cause_o), .redir_o(redir_o), .fetch_pc_o(fetch_pc_o)
);

// File: tb/xcpt_flush_ctrl_tb_top.sv
module xcpt_flush_ctrl_tb_top;
  localparam int          CLK_NS = 10;
  localparam logic [31:0] HPC    = 32'h4000_0040;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        adv_i;
  logic [3:0]  stg_vld_i;
  logic [3:0]  xreq_i;
  logic [11:0] xcause_i;
  logic [31:0] mem_pc_i;
  logic [31:0] nxt_pc_i;
  logic        take_o;
  logic [4:0]  flush_o;
  logic [31:0] epc_o;
  logic [2:0]  cause_o;
  logic        redir_o;
  logic [31:0] fetch_pc_o;

  xcpt_flush_ctrl dut_i (.*);

  always #(CLK_NS/2) clk_i = ~clk_i;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;
  bit mon_on = 0;

  typedef struct {
    int          at;
    logic [2:0]  code;
    logic [31:0] epc;
    string       tag;
  } exp_t;
  exp_t expq[$];
  exp_t held;
  bit   post_chk = 0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] cz(input int s, input logic [2:0] code);
    return 12'(code) << (3*s);
  endfunction

  task automatic exp_take(input logic [2:0] code, input logic [31:0] epc, input string tag);
    exp_t e;
    e.at = cyc; e.code = code; e.epc = epc; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic drive(input logic [3:0] v, input logic [3:0] r, input logic [11:0] c,
                       input logic [31:0] pc, input logic a);
    stg_vld_i = v; xreq_i = r; xcause_i = c; mem_pc_i = pc; adv_i = a;
  endtask

  task automatic step(input logic [3:0] v, input logic [3:0] r, input logic [11:0] c,
                      input logic [31:0] pc, input logic a);
    drive(v, r, c, pc, a);
    @(posedge clk_i); #1;
  endtask

  task automatic step_nt(input logic [3:0] v, input logic [3:0] r, input logic [11:0] c,
                         input logic [31:0] pc, input logic a, input string req);
    drive(v, r, c, pc, a);
    @(negedge clk_i);
    chk(take_o == 1'b0, req, 32'(take_o), 32'h0);
    @(posedge clk_i); #1;
  endtask

  // monitor: pops the scoreboard on every take and checks the next-cycle state
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (post_chk) begin
        post_chk = 0;
        chk(redir_o == 1'b1, "R8 redirect", 32'(redir_o), 32'h1);
        chk(fetch_pc_o == HPC, "R8 handler pc", fetch_pc_o, HPC);
        chk(epc_o == held.epc, {"R6 epc ", held.tag}, epc_o, held.epc);
        chk(cause_o == held.code, {"R7 cause ", held.tag}, 32'(cause_o), 32'(held.code));
      end
      if (take_o) begin
        if (expq.size() == 0) begin
          chk(1'b0, "R5 unexpected take", 32'(cyc), 32'h0);
        end else begin
          held = expq.pop_front();
          chk(cyc == held.at, {"R3 take cycle ", held.tag}, 32'(cyc), 32'(held.at));
          chk(flush_o == 5'b01111, "R2 flush mask", 32'(flush_o), 32'h0f);
          post_chk = 1;
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    drive(4'hF, 4'h0, 12'h0, 32'h0, 1'b1);
    nxt_pc_i = 32'h0000_0abc;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    // R1 reset state
    chk(take_o == 1'b0, "R1 take", 32'(take_o), 32'h0);
    chk(flush_o == 5'b0, "R1 flush", 32'(flush_o), 32'h0);
    chk(redir_o == 1'b0, "R1 redir", 32'(redir_o), 32'h0);
    chk(epc_o == 32'h0, "R1 epc", epc_o, 32'h0);
    chk(cause_o == 3'd0, "R1 cause", 32'(cause_o), 32'h0);
    chk(fetch_pc_o == nxt_pc_i, "R1 fetch pc", fetch_pc_o, nxt_pc_i);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk_i);
    #1;
    mon_on = 1;

    // R2/R7: lone memory-stage page fault
    exp_take(3'd3, 32'h104, "R2");
    step(4'hF, 4'b1000, cz(3, 3'd3), 32'h100, 1'b1);
    step(4'hF, 4'h0, 12'h0, 32'h0, 1'b1);
    step(4'hF, 4'h0, 12'h0, 32'h0, 1'b1);

    // R4: execute overflow and memory page fault together, older wins
    exp_take(3'd3, 32'h204, "R4");
    step(4'hF, 4'b1100, cz(2, 3'd2) | cz(3, 3'd3), 32'h200, 1'b1);
    for (int i = 0; i < 5; i++) step_nt(4'hF, 4'h0, 12'h0, 32'h0, 1'b1, "R5 flushed flag");

    // R5: younger fetch fault one cycle before older memory syscall
    step_nt(4'hF, 4'b0001, cz(0, 3'd4), 32'h0, 1'b1, "R3 fetch flag deferred");
    exp_take(3'd1, 32'h304, "R5");
    step(4'hF, 4'b1000, cz(3, 3'd1), 32'h300, 1'b1);
    for (int i = 0; i < 5; i++) step_nt(4'hF, 4'h0, 12'h0, 32'h0, 1'b1, "R5 younger discarded");

    // R3: decode syscall carried down with one stall cycle
    step_nt(4'hF, 4'b0010, cz(1, 3'd1), 32'h0, 1'b1, "R3 decode flag");
    step_nt(4'hF, 4'h0, 12'h0, 32'h0, 1'b0, "R3 stall");
    step_nt(4'hF, 4'h0, 12'h0, 32'h0, 1'b1, "R3 in execute");
    exp_take(3'd1, 32'h404, "R3");
    step(4'hF, 4'h0, 12'h0, 32'h400, 1'b1);
    step(4'hF, 4'h0, 12'h0, 32'h0, 1'b1);

    // R9: flags in invalid stages
    step_nt(4'b0111, 4'b1000, cz(3, 3'd3), 32'h600, 1'b1, "R9 invalid memory");
    step_nt(4'b1011, 4'b0100, cz(2, 3'd2), 32'h0, 1'b1, "R9 invalid execute");
    for (int i = 0; i < 3; i++) step_nt(4'hF, 4'h0, 12'h0, 32'h0, 1'b1, "R9 no late take");

    // R10: execute overflow carried, memory page fault on same instruction
    step_nt(4'hF, 4'b0100, cz(2, 3'd2), 32'h0, 1'b1, "R10 execute flag");
    exp_take(3'd2, 32'h504, "R10");
    step(4'hF, 4'b1000, cz(3, 3'd3), 32'h500, 1'b1);
    step(4'hF, 4'h0, 12'h0, 32'h0, 1'b1);

    // R7 external request, then R9 flag in redirect cycle ignored
    exp_take(3'd0, 32'h704, "R7 ext");
    step(4'hF, 4'b1000, cz(3, 3'd0), 32'h700, 1'b1);
    step_nt(4'hF, 4'b1000, cz(3, 3'd4), 32'h800, 1'b1, "R9 redirect cycle");
    step(4'hF, 4'h0, 12'h0, 32'h0, 1'b1);

    // R8 passthrough and R6 hold
    nxt_pc_i = 32'h0000_1234;
    @(negedge clk_i);
    chk(fetch_pc_o == 32'h1234, "R8 passthrough", fetch_pc_o, 32'h1234);
    chk(redir_o == 1'b0, "R8 redir low", 32'(redir_o), 32'h0);
    chk(epc_o == 32'h704, "R6 hold epc", epc_o, 32'h704);
    chk(cause_o == 3'd0, "R6 hold cause", 32'(cause_o), 32'h0);
    repeat (3) @(posedge clk_i);
    #1;
    chk(expq.size() == 0, "R5 missing take", 32'(expq.size()), 32'h0);

    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule